// File: doc/BRIEF.md
# Bus-Mapped Watchdog Timer with Gated Reset Request

This block is a watchdog peripheral on a simple 32-bit register bus: a byte address, a write strobe, write data, and read data returned one clock after the address is presented. Software writes a start count into a 32-bit duration register, sets the run bit, and then rewrites the duration register from time to time. Each rewrite is a keep-alive that puts a new count into the down-counter. Reading the duration register returns the count that is left, so software can work out how much time remains.

The counter steps on one of two sources. The first is the system clock divided by a power of two taken from a 3-bit ratio field. The second is a fixed reference presented as a synchronous tick-enable input, which bypasses the divider. When the count runs out, the block latches a sticky expired flag that software must clear and emits a one-cycle interrupt pulse. It also raises a reset request level, but only while the timer runs, the reset-out enable is set and the reset mask is clear.

Top module: `wdog_timer`

## Requirements
- R1: After reset the control register (offset 0x00) reads 0, status (0x04) reads 0, duration (0x34) reads 0xFFFFFFFF, reset-out enable (0x08) reads 0, and mask (0x0C) reads 0x400, with irq_expire and rst_req low. Only defined bits read back: control returns bit 8 (run), bit 10 (reference select) and bits 18:16 (ratio), and every other bit reads 0.
- R2: Writing offset 0x34 loads the counter. A read of 0x34 returns the count held just before the clock edge that captures the read, on bus_rdata after that edge.
- R3: While control bit 8 is 0 the counter holds its value. After bit 8 is set, the first decrement comes 2^ratio clocks after the enabling write.
- R4: With bit 10 clear, the counter decrements once every 2^R clocks, where R is control bits 18:16. A write to 0x34 restarts the divider phase.
- R5: With bit 10 set, the counter decrements once on every clock where ref_tick is high, whatever the ratio field holds.
- R6: When a decrement takes the count from 1 to 0, the counter stays at 0, status bit 31 becomes 1, and irq_expire is high for exactly the one cycle after that edge.
- R7: Status bit 31 is sticky. Writing 0x04 with bit 31 = 0 clears it, and writing bit 31 = 1 has no effect. If an expiry and a clear fall on the same edge, the flag ends up set.
- R8: rst_req rises one clock after the counter has expired while run = 1, reset-out enable bit 8 at 0x08 = 1 and mask bit 10 at 0x0C = 0. It falls one clock after any of these is removed or after the duration register is reloaded.
- R9: irq_expire pulses on expiry even when the reset request is gated off.
- R10: A duration write on the edge of the final decrement wins: the new value is loaded, and no expiry, flag or interrupt occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the address of the previous cycle |
| ref_tick | input | 1 | Fixed reference tick-enable, synchronous to clk |
| irq_expire | output | 1 | One-cycle expiry interrupt pulse |
| rst_req | output | 1 | Gated reset request level |

## Verification
Two pairs of events can land on the same clock edge. An expiry can coincide with a software write that clears the sticky flag, and the final decrement can coincide with a keep-alive reload. The bench counts edges from the duration write and places the clear or reload write exactly on the edge of the 1-to-0 step. It then reads the status register and the duration register back, and it watches irq_expire: a set flag after the clear means expiry won, and a count equal to the new value with no pulse means the reload won. The random part draws durations and ratios, reads the count at arbitrary points, and compares both the count and the flag against closed-form expectations.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W      = 32;
  localparam int RATIO_W     = 3;

  localparam int OFS_CTRL    = 'h00;
  localparam int OFS_STAT    = 'h04;
  localparam int OFS_RSTEN   = 'h08;
  localparam int OFS_MASK    = 'h0C;
  localparam int OFS_DUR     = 'h34;

  localparam int BIT_RUN     = 8;
  localparam int BIT_REFSEL  = 10;
  localparam int RATIO_LSB   = 16;
  localparam int BIT_EXPIRED = 31;
  localparam int BIT_OUTEN   = 8;
  localparam int BIT_MASK    = 10;

  typedef struct packed {
    logic [RATIO_W-1:0] ratio;
    logic               ref_sel;
    logic               run;
  } ctrl_t;
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run,
  input  logic               restart,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               use_ref,
  input  logic               ref_tick,
  output logic               tick
);
  localparam int PRE_W = (1 << RATIO_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] phase_mask;
  logic             div_tick;

  // Thermometer mask of the low 'ratio' bits of the phase counter.
  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign phase_mask[i] = (ratio > RATIO_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (!run || restart || use_ref) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  assign div_tick = ((pre_q & phase_mask) == phase_mask);
  assign tick     = run && (use_ref ? ref_tick : div_tick);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire,
  output logic             fired
);
  logic [CNT_W-1:0] cnt_q;
  logic             fired_q;

  assign expire = tick && !load && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fired_q <= 1'b0;
    end else if (load) begin
      fired_q <= 1'b0;
    end else if (expire) begin
      fired_q <= 1'b1;
    end
  end

  assign count = cnt_q;
  assign fired = fired_q;
endmodule

// File: rtl/wdog_rstgate.sv
module wdog_rstgate (
  input  logic clk,
  input  logic rst,
  input  logic fired,
  input  logic run,
  input  logic out_en,
  input  logic masked,
  output logic rst_req
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
    end else begin
      req_q <= fired && run && out_en && !masked;
    end
  end

  assign rst_req = req_q;
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ref_tick,
  output logic              irq_expire,
  output logic              rst_req
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_RSTEN = ADDR_W'(OFS_RSTEN);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_DUR   = ADDR_W'(OFS_DUR);

  logic wr_ctrl, wr_stat, wr_rsten, wr_mask, wr_dur;
  ctrl_t ctrl_q;
  logic rsten_q, mask_q, expired_q, irq_q;
  logic run_en, tick, expire, fired;
  logic [CNT_W-1:0]  cnt_val;
  logic [DATA_W-1:0] cnt_ext;
  logic [DATA_W-1:0] rd_next, rdata_q;
  logic unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  assign wr_stat  = bus_we && (bus_addr == A_STAT);
  assign wr_rsten = bus_we && (bus_addr == A_RSTEN);
  assign wr_mask  = bus_we && (bus_addr == A_MASK);
  assign wr_dur   = bus_we && (bus_addr == A_DUR);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q.run     <= bus_wdata[BIT_RUN];
      ctrl_q.ref_sel <= bus_wdata[BIT_REFSEL];
      ctrl_q.ratio   <= bus_wdata[RATIO_LSB +: RATIO_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsten_q <= 1'b0;
      mask_q  <= 1'b1;
    end else begin
      if (wr_rsten) rsten_q <= bus_wdata[BIT_OUTEN];
      if (wr_mask)  mask_q  <= bus_wdata[BIT_MASK];
    end
  end

  assign run_en = ctrl_q.run;

  wdog_prescale #(.RATIO_W(RATIO_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .run      (run_en),
    .restart  (wr_dur),
    .ratio    (ctrl_q.ratio),
    .use_ref  (ctrl_q.ref_sel),
    .ref_tick (ref_tick),
    .tick     (tick)
  );

  wdog_count #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .load     (wr_dur),
    .load_val (bus_wdata[CNT_W-1:0]),
    .count    (cnt_val),
    .expire   (expire),
    .fired    (fired)
  );

  wdog_rstgate u_gate (
    .clk     (clk),
    .rst     (rst),
    .fired   (fired),
    .run     (run_en),
    .out_en  (rsten_q),
    .masked  (mask_q),
    .rst_req (rst_req)
  );

  // Expiry takes priority over a software clear on the same edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      expired_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= expire;
      if (expire) begin
        expired_q <= 1'b1;
      end else if (wr_stat && !bus_wdata[BIT_EXPIRED]) begin
        expired_q <= 1'b0;
      end
    end
  end

  assign cnt_ext = DATA_W'(cnt_val);

  always_comb begin
    rd_next = '0;
    case (bus_addr)
      A_CTRL: begin
        rd_next[BIT_RUN]                 = ctrl_q.run;
        rd_next[BIT_REFSEL]              = ctrl_q.ref_sel;
        rd_next[RATIO_LSB +: RATIO_W]    = ctrl_q.ratio;
      end
      A_STAT:  rd_next[BIT_EXPIRED] = expired_q;
      A_RSTEN: rd_next[BIT_OUTEN]   = rsten_q;
      A_MASK:  rd_next[BIT_MASK]    = mask_q;
      A_DUR:   rd_next              = cnt_ext;
      default: rd_next              = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign bus_rdata  = rdata_q;
  assign irq_expire = irq_q;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk (
  input logic        clk,
  input logic        rst,
  input logic        irq,
  input logic        rst_req,
  input logic        expired,
  input logic [31:0] count,
  input logic        run,
  input logic        out_en,
  input logic        masked,
  input logic        load,
  input logic        stat_wr,
  input logic        stat_bit
);
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(count)); // R3

  AST_STEP_AT_MOST_ONE: assert property (@(posedge clk) disable iff (rst)
    !load |=> (count == $past(count)) || (count == $past(count) - 32'd1)); // R4

  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
    (count == 32'd0 && !load) |=> (count == 32'd0)); // R6

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R6

  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> expired); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (expired && !(stat_wr && !stat_bit)) |=> expired); // R7

  AST_RST_GATED: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(run && out_en && !masked)); // R8

  AST_RELOAD_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
    load |=> !irq); // R10
endmodule

bind wdog_timer wdog_timer_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq_expire),
  .rst_req  (rst_req),
  .expired  (expired_q),
  .count    (cnt_ext),
  .run      (run_en),
  .out_en   (rsten_q),
  .masked   (mask_q),
  .load     (wr_dur),
  .stat_wr  (wr_stat),
  .stat_bit (bus_wdata[31])
);

// File: tb/wdog_timer_test.sv
`timescale 1ns/1ps
module wdog_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ref_tick = 1'b0;
  logic        irq_expire;
  logic        rst_req;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  localparam logic [7:0] CTRL = 8'h00, STAT = 8'h04, OUTEN = 8'h08, MASK = 8'h0C, DUR = 8'h34;

  always #2.5 clk = ~clk;

  wdog_timer uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ref_tick(ref_tick),
    .irq_expire(irq_expire), .rst_req(rst_req)
  );

  function automatic logic [31:0] exp_cnt(int d, int r, int k);
    int v;
    v = d - (k >> r);
    return (v < 0) ? 32'd0 : 32'(v);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called right after a negedge; returns right after the next negedge.
  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    v = bus_rdata;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", 32'(irq_expire), 0);
    chk("R1 rst_req", 32'(rst_req), 0);
    rd(CTRL, v);  chk("R1 ctrl", v, 32'h0);
    rd(STAT, v);  chk("R1 stat", v, 32'h0);
    rd(DUR, v);   chk("R1 dur", v, 32'hFFFF_FFFF);
    rd(OUTEN, v); chk("R1 outen", v, 32'h0);
    rd(MASK, v);  chk("R1 mask", v, 32'h400);
    wr(CTRL, 32'hFFFF_FFFF);
    rd(CTRL, v);  chk("R1 ctrl fields", v, 32'h0007_0500);
    wr(CTRL, 32'h0);

    // R3 hold while stopped, R2 load and readback
    wr(DUR, 32'd100);
    repeat (10) @(negedge clk);
    rd(DUR, v); chk("R3 hold", v, 32'd100);
    wr(CTRL, 32'h100);
    repeat (7) @(negedge clk);
    rd(DUR, v); chk("R2 count", v, 32'd93);

    // R4 ratio 5 -> one step per 32 clocks
    wr(CTRL, 32'h0);
    wr(DUR, 32'd4);
    wr(CTRL, 32'h0005_0100);
    repeat (31) @(negedge clk);
    rd(DUR, v); chk("R4 before step", v, 32'd4);
    rd(DUR, v); chk("R4 after step", v, 32'd3);

    // R5 reference ticks, ratio ignored
    wr(CTRL, 32'h0);
    wr(DUR, 32'd10);
    wr(CTRL, 32'h0007_0500);
    for (int i = 0; i < 3; i++) begin
      ref_tick = 1'b1; @(negedge clk);
      ref_tick = 1'b0; @(negedge clk);
    end
    repeat (5) @(negedge clk);
    rd(DUR, v); chk("R5 ref count", v, 32'd7);

    // R6 / R9 expiry with reset-out disabled
    wr(CTRL, 32'h0);
    wr(STAT, 32'h0);
    wr(DUR, 32'd3);
    wr(CTRL, 32'h100);
    @(negedge clk); chk("R6 irq early1", 32'(irq_expire), 0);
    @(negedge clk); chk("R6 irq early2", 32'(irq_expire), 0);
    @(negedge clk); chk("R6 irq pulse", 32'(irq_expire), 1);
    @(negedge clk); chk("R6 irq single", 32'(irq_expire), 0);
    chk("R9 no rst_req", 32'(rst_req), 0);
    rd(STAT, v); chk("R6 flag", v, 32'h8000_0000);
    rd(DUR, v);  chk("R6 zero", v, 32'd0);
    repeat (4) @(negedge clk);
    rd(DUR, v);  chk("R6 stays zero", v, 32'd0);

    // R8 gating
    wr(OUTEN, 32'h100);
    @(negedge clk); chk("R8 masked", 32'(rst_req), 0);
    wr(MASK, 32'h0);
    chk("R8 latency", 32'(rst_req), 0);
    @(negedge clk); chk("R8 asserted", 32'(rst_req), 1);
    wr(MASK, 32'h400);
    chk("R8 still high", 32'(rst_req), 1);
    @(negedge clk); chk("R8 mask drops", 32'(rst_req), 0);
    wr(MASK, 32'h0);
    @(negedge clk); chk("R8 reasserted", 32'(rst_req), 1);
    wr(DUR, 32'd50);
    @(negedge clk); chk("R8 reload drops", 32'(rst_req), 0);
    chk("R9 irq quiet", 32'(irq_expire), 0);
    wr(MASK, 32'h400);

    // R7 sticky flag and collision
    wr(CTRL, 32'h0);
    wr(STAT, 32'h7FFF_FFFF);
    rd(STAT, v); chk("R7 clear", v, 32'h0);
    wr(STAT, 32'h8000_0000);
    rd(STAT, v); chk("R7 write1 noop", v, 32'h0);
    wr(DUR, 32'd3);
    wr(CTRL, 32'h100);
    repeat (2) @(negedge clk);
    wr(STAT, 32'h0);
    rd(STAT, v); chk("R7 expiry wins", v, 32'h8000_0000);
    wr(STAT, 32'h8000_0000);
    rd(STAT, v); chk("R7 write1 keeps", v, 32'h8000_0000);

    // R10 reload on the final step
    wr(STAT, 32'h0);
    wr(CTRL, 32'h0);
    wr(DUR, 32'd3);
    wr(CTRL, 32'h100);
    repeat (2) @(negedge clk);
    wr(DUR, 32'd5);
    chk("R10 no irq", 32'(irq_expire), 0);
    rd(DUR, v);  chk("R10 reload value", v, 32'd5);
    rd(STAT, v); chk("R10 no flag", v, 32'h0);

    // Random: R2 R4 R6
    for (int it = 0; it < 16; it++) begin
      int d, r, k;
      d = 2 + int'($urandom % 30);
      r = int'($urandom % 4);
      k = int'($urandom % ((d << r) + 4));
      wr(CTRL, 32'h0);
      wr(STAT, 32'h0);
      wr(DUR, 32'(d));
      wr(CTRL, 32'h100 | (32'(r) << 16));
      repeat (k) @(negedge clk);
      rd(DUR, v);  chk("R2 R4 random count", v, exp_cnt(d, r, k));
      rd(STAT, v); chk("R6 random flag", v, ((k + 1) >= (d << r)) ? 32'h8000_0000 : 32'h0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule